// File: doc/BRIEF.md
# Wait-for-event hint controller

This block carries out the wait-for-event hint for a simple processing element. It recognises the hint in three encodings: a 32-bit fixed-length word, a 16-bit compressed halfword and a 32-bit compressed pair of halfwords. It holds a one-bit event flag. That flag is set by a send-event pulse broadcast from any element in the system, or by another event source.

When a matching hint whose condition passes is issued and the flag is set, the block clears the flag and retires the hint at once. Otherwise it looks at the trap controls of the privilege levels in a fixed order. The first trap that applies is reported with its target level, and the hint does not sleep. If no trap applies, the block enters a low-power state. A wake event ends that state: a send-event, another event, a pending interrupt or a debug request. The hint then retires.

The pipeline around the block evaluates the condition code and takes the exception. This block only reports the trap.

Top module: `evt_wait_ctrl`

## Requirements
- R1: With `isa_sel`=0 the hint matches when `instr[31:28]` is not 4'hF, `instr[27:16]` equals 12'h320 and `instr[7:0]` equals 8'h02. Bits 15:8 are ignored. A non-matching word causes no retire, no trap and no sleep, and leaves the event flag unchanged.
- R2: With `isa_sel`=1 the hint matches when `instr[15:0]` is 16'hBF20. With `isa_sel`=2 it matches when `instr[31:20]` is 12'hF3A and `instr[15:0]` masked with 16'hD7FF equals 16'h8002, so bits 19:16, 13 and 11 are ignored. `isa_sel`=3 never matches.
- R3: An accepted hint with `cond_pass`=0 raises `retire` for one cycle, starting one cycle after issue. It does not change the event flag and raises neither a trap nor `low_power`.
- R4: An accepted hint with `cond_pass`=1 while `evt_pending` is 1 clears the flag and raises `retire` one cycle after issue. No trap is checked and no sleep is entered.
- R5: `send_evt` or `other_evt` sets `evt_pending` at the next edge. A set in the same cycle as a consume wins.
- R6: Traps are checked in this order: undefined, OS, hypervisor, monitor. The undefined trap needs `top_present`, `top_undef_prio` and `mon_trap_en` all to be 1. It reports `trap_undef`=1 and `trap_level`=3.
- R7: The OS trap applies when `cur_lvl`=0 and `os_trap_n`=0. It reports `trap_level`=1.
- R8: The hypervisor trap applies when `cur_lvl`≤1, `hyp_enabled`=1, `host_mode`=0 and `hyp_trap_en`=1. It reports `trap_level`=2.
- R9: The monitor trap applies when `top_present`=1, `monitor_mode`=0 and `mon_trap_en`=1. It reports `trap_level`=3 with `trap_undef`=0.
- R10: `trap_valid` is a one-cycle pulse two cycles after issue. It is never followed by `low_power`.
- R11: With no trap, `low_power` rises two cycles after issue. It stays high until a cycle in which a wake input is high, and falls at the next edge. `retire` pulses one cycle later, and the event flag is cleared at that retire edge unless it is set again in the same cycle.
- R12: A hint presented while the block is not idle is ignored.
- R13: At most one of `retire`, `trap_valid` and `low_power` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| isa_sel | input | 2 | Encoding: 0 fixed, 1 compressed 16, 2 compressed 32 |
| instr | input | 32 | Instruction bits |
| cond_pass | input | 1 | Condition check passed |
| send_evt | input | 1 | System send-event pulse |
| other_evt | input | 1 | Other event source |
| irq_pend | input | 1 | Pending interrupt (wake only) |
| dbg_req | input | 1 | Debug request (wake only) |
| cur_lvl | input | 2 | Current privilege level |
| monitor_mode | input | 1 | Running in monitor mode |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| host_mode | input | 1 | Host mode active |
| top_present | input | 1 | Highest level implemented |
| top_undef_prio | input | 1 | Debug-disable gives undefined priority |
| os_trap_n | input | 1 | OS trap control, 0 means trap |
| hyp_trap_en | input | 1 | Hypervisor trap enable |
| mon_trap_en | input | 1 | Monitor trap enable |
| retire | output | 1 | Hint completes |
| trap_valid | output | 1 | Trap raised |
| trap_level | output | 2 | Trap target level |
| trap_undef | output | 1 | Trap is undefined-instruction |
| low_power | output | 1 | In low-power wait |
| evt_pending | output | 1 | Event flag |

## Verification
The bench sets the event flag in the same cycle as each kind of consume. A design that gave the clear priority would lose that event. It enables several traps at once at each level. A wrong priority order would then report the wrong level, and a missing qualifier such as host mode or monitor mode would trap where the hint should sleep. It also tries the tolerated don't-care bits, the reserved condition value, a failing condition and issues made during sleep. A decoder that is too strict or too loose would retire when it should not, or stay silent when it should retire. A missing condition gate would eat the event flag.

// File: rtl/evt_wait_ctrl.sv
module evt_wait_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_valid,
  input  logic [1:0]  isa_sel,
  input  logic [31:0] instr,
  input  logic        cond_pass,
  input  logic        send_evt,
  input  logic        other_evt,
  input  logic        irq_pend,
  input  logic        dbg_req,
  input  logic [1:0]  cur_lvl,
  input  logic        monitor_mode,
  input  logic        hyp_enabled,
  input  logic        host_mode,
  input  logic        top_present,
  input  logic        top_undef_prio,
  input  logic        os_trap_n,
  input  logic        hyp_trap_en,
  input  logic        mon_trap_en,
  output logic        retire,
  output logic        trap_valid,
  output logic [1:0]  trap_level,
  output logic        trap_undef,
  output logic        low_power,
  output logic        evt_pending
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SLEEP, S_WAKE} st_t;

  localparam logic [1:0] LVL_OS  = 2'd1;
  localparam logic [1:0] LVL_HYP = 2'd2;
  localparam logic [1:0] LVL_MON = 2'd3;

  st_t  state;
  logic match, accept, wake, ev_set, ev_use;
  logic t_undef, t_os, t_hyp, t_mon;
  logic unused_ok;

  always_comb begin
    case (isa_sel)
      2'd0:    match = (instr[31:28] != 4'hF) && (instr[27:16] == 12'h320) && (instr[7:0] == 8'h02);
      2'd1:    match = (instr[15:0] == 16'hBF20);
      2'd2:    match = (instr[31:20] == 12'hF3A) && ((instr[15:0] & 16'hD7FF) == 16'h8002);
      default: match = 1'b0;
    endcase
  end

  assign unused_ok = ^instr[15:8];

  assign accept = issue_valid && (state == S_IDLE) && match;
  assign wake   = send_evt | other_evt | irq_pend | dbg_req;
  assign ev_set = send_evt | other_evt;
  assign ev_use = (accept && cond_pass && evt_pending) || (state == S_WAKE);

  assign t_undef = top_present && top_undef_prio && mon_trap_en;
  assign t_os    = (cur_lvl == 2'd0) && !os_trap_n;
  assign t_hyp   = (cur_lvl <= 2'd1) && hyp_enabled && !host_mode && hyp_trap_en;
  assign t_mon   = top_present && !monitor_mode && mon_trap_en;

  assign low_power = (state == S_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) evt_pending <= 1'b0;
    else if (ev_set) evt_pending <= 1'b1;
    else if (ev_use) evt_pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      retire     <= 1'b0;
      trap_valid <= 1'b0;
      trap_level <= 2'd0;
      trap_undef <= 1'b0;
    end else begin
      retire     <= 1'b0;
      trap_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (accept) begin
            if (!cond_pass || evt_pending) retire <= 1'b1;
            else state <= S_CHECK;
          end
        S_CHECK: begin
          state <= S_IDLE;
          if (t_undef) begin
            trap_valid <= 1'b1; trap_level <= LVL_MON; trap_undef <= 1'b1;
          end else if (t_os) begin
            trap_valid <= 1'b1; trap_level <= LVL_OS;  trap_undef <= 1'b0;
          end else if (t_hyp) begin
            trap_valid <= 1'b1; trap_level <= LVL_HYP; trap_undef <= 1'b0;
          end else if (t_mon) begin
            trap_valid <= 1'b1; trap_level <= LVL_MON; trap_undef <= 1'b0;
          end else begin
            state <= S_SLEEP;
          end
        end
        S_SLEEP:
          if (wake) state <= S_WAKE;
        S_WAKE: begin
          retire <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_wait_ctrl_chk.sv
module evt_wait_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       send_evt,
  input logic       other_evt,
  input logic       irq_pend,
  input logic       dbg_req,
  input logic [1:0] cur_lvl,
  input logic       monitor_mode,
  input logic       hyp_enabled,
  input logic       host_mode,
  input logic       top_present,
  input logic       retire,
  input logic       trap_valid,
  input logic [1:0] trap_level,
  input logic       trap_undef,
  input logic       low_power,
  input logic       evt_pending
);
  logic wk;
  assign wk = send_evt | other_evt | irq_pend | dbg_req;

  p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire, trap_valid, low_power}));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (send_evt || other_evt) |=> evt_pending);

  p_undef_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_undef) |-> (trap_level == 2'd3));

  p_os_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_level == 2'd1) |-> ($past(cur_lvl) == 2'd0));

  p_hyp_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_level == 2'd2) |-> ($past(cur_lvl) <= 2'd1 && $past(hyp_enabled) && !$past(host_mode)));

  p_mon_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_level == 2'd3 && !trap_undef) |-> ($past(top_present) && !$past(monitor_mode)));

  p_trap_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (!trap_valid && !low_power));

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !wk) |=> low_power);

  p_wake_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && wk) |=> !low_power ##1 retire);
endmodule

bind evt_wait_ctrl evt_wait_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .send_evt(send_evt), .other_evt(other_evt),
  .irq_pend(irq_pend), .dbg_req(dbg_req), .cur_lvl(cur_lvl),
  .monitor_mode(monitor_mode), .hyp_enabled(hyp_enabled), .host_mode(host_mode),
  .top_present(top_present), .retire(retire), .trap_valid(trap_valid),
  .trap_level(trap_level), .trap_undef(trap_undef), .low_power(low_power),
  .evt_pending(evt_pending));

// File: tb/test_evt_wait_ctrl.sv
`timescale 1ns/1ps
module test_evt_wait_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 0, cond_pass = 1;
  logic [1:0] isa_sel = 0;
  logic [31:0] instr = 0;
  logic send_evt = 0, other_evt = 0, irq_pend = 0, dbg_req = 0;
  logic [1:0] cur_lvl = 2'd1;
  logic monitor_mode = 0, hyp_enabled = 0, host_mode = 0, top_present = 0, top_undef_prio = 0;
  logic os_trap_n = 1, hyp_trap_en = 0, mon_trap_en = 0;
  logic retire, trap_valid, trap_undef, low_power, evt_pending;
  logic [1:0] trap_level;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  evt_wait_ctrl i_evt_wait_ctrl (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic set_evt();
    send_evt = 1; tick(); send_evt = 0;
  endtask

  // issue for one edge; leaves signals sampled one cycle after issue
  task automatic issue(input logic [1:0] sel, input logic [31:0] w, input logic cp);
    isa_sel = sel; instr = w; cond_pass = cp; issue_valid = 1;
    tick();
    issue_valid = 0;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " no retire"}, retire, 0);
    chk({tag, " no trap"}, trap_valid, 0);
    chk({tag, " no sleep"}, low_power, 0);
  endtask

  task automatic t_reset();
    chk("reset retire", retire, 0);
    chk("reset trap", trap_valid, 0);
    chk("reset low_power", low_power, 0);
    chk("reset evt", evt_pending, 0);
  endtask

  // R1 R2 R4: fast retire for matching encodings with flag set
  task automatic t_decode_hit(input logic [1:0] sel, input logic [31:0] w, input string tag);
    set_evt();
    chk({tag, " R5 evt set"}, evt_pending, 1);
    issue(sel, w, 1);
    chk({tag, " R4 retire"}, retire, 1);
    chk({tag, " R4 evt cleared"}, evt_pending, 0);
    chk({tag, " R4 no trap"}, trap_valid, 0);
    tick();
    quiet({tag, " R4 after"});
  endtask

  task automatic t_decode_miss(input logic [1:0] sel, input logic [31:0] w, input string tag);
    set_evt();
    issue(sel, w, 1);
    quiet(tag);
    tick();
    quiet(tag);
    chk({tag, " evt kept"}, evt_pending, 1);
    issue(2'd1, 32'h0000BF20, 1);
    tick();
  endtask

  task automatic t_cond_fail();
    set_evt();
    issue(2'd0, 32'hE320F002, 0);
    chk("R3 retire", retire, 1);
    chk("R3 evt unchanged", evt_pending, 1);
    chk("R3 no trap", trap_valid, 0);
    tick();
    chk("R3 no sleep", low_power, 0);
    issue(2'd1, 32'h0000BF20, 1);
    tick();
  endtask

  task automatic t_set_wins_idle();
    set_evt();
    send_evt = 1;
    issue(2'd1, 32'h0000BF20, 1);
    send_evt = 0;
    chk("R5 retire", retire, 1);
    chk("R5 set wins over consume", evt_pending, 1);
    issue(2'd1, 32'h0000BF20, 1);
    tick();
  endtask

  // expects lvl==0 for the sleep path
  task automatic t_trap(input logic [1:0] lvl, input logic und, input string tag);
    issue(2'd0, 32'hE320F002, 1);
    chk({tag, " check cycle quiet"}, trap_valid | low_power | retire, 0);
    tick();
    if (lvl != 0) begin
      chk({tag, " R10 trap_valid"}, trap_valid, 1);
      chk({tag, " trap_level"}, trap_level, lvl);
      chk({tag, " trap_undef"}, trap_undef, und);
      chk({tag, " R10 no sleep"}, low_power, 0);
      tick();
      chk({tag, " R10 pulse ends"}, trap_valid | low_power, 0);
    end else begin
      chk({tag, " R11 sleeping"}, low_power, 1);
      chk({tag, " no trap"}, trap_valid, 0);
      dbg_req = 1; tick(); dbg_req = 0;
      chk({tag, " R11 woke"}, low_power, 0);
      tick();
      chk({tag, " R11 retire"}, retire, 1);
    end
    tick();
  endtask

  task automatic t_sleep_wake();
    issue(2'd2, 32'hF3AF8002, 1);
    tick();
    chk("R11 low_power", low_power, 1);
    tick(); tick();
    chk("R11 holds", low_power, 1);
    issue(2'd1, 32'h0000BF20, 1);
    chk("R12 still sleeping", low_power, 1);
    chk("R12 no retire", retire, 0);
    irq_pend = 1; tick(); irq_pend = 0;
    chk("R11 wake by irq", low_power, 0);
    chk("R11 no retire yet", retire, 0);
    tick();
    chk("R11 retire", retire, 1);
    chk("R11 evt clear", evt_pending, 0);
    tick();
    issue(2'd0, 32'hE320F002, 1);
    tick();
    chk("R11 sleep again", low_power, 1);
    send_evt = 1; tick(); send_evt = 0;
    chk("R11 wake by send", low_power, 0);
    chk("R5 evt set by send", evt_pending, 1);
    tick();
    chk("R11 retire2", retire, 1);
    chk("R11 evt consumed at wake", evt_pending, 0);
    tick();
    issue(2'd0, 32'hE320F002, 1);
    tick();
    other_evt = 1; tick();
    chk("R5 other wake", low_power, 0);
    tick(); other_evt = 0;
    chk("R11 retire3", retire, 1);
    chk("R5 set wins at wake", evt_pending, 1);
    issue(2'd1, 32'h0000BF20, 1);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_decode_hit(2'd0, 32'hE320F002, "R1 fixed");
    t_decode_hit(2'd0, 32'h03200A02, "R1 fixed tolerated bits");
    t_decode_hit(2'd1, 32'h0000BF20, "R2 c16");
    t_decode_hit(2'd2, 32'hF3AF8002, "R2 c32");
    t_decode_hit(2'd2, 32'hF3A0A802, "R2 c32 tolerated bits");
    t_decode_miss(2'd0, 32'hF320F002, "R1 cond 1111 miss");
    t_decode_miss(2'd0, 32'hE320F003, "R1 low byte miss");
    t_decode_miss(2'd1, 32'h0000BF30, "R2 c16 miss");
    t_decode_miss(2'd2, 32'hF3AF8003, "R2 c32 miss");
    t_decode_miss(2'd3, 32'h0000BF20, "R2 sel3 miss");
    t_cond_fail();
    t_set_wins_idle();
    t_sleep_wake();
    t_trap(2'd0, 0, "R11 no traps");
    top_present = 1; top_undef_prio = 1; mon_trap_en = 1;
    cur_lvl = 0; os_trap_n = 0; hyp_enabled = 1; hyp_trap_en = 1;
    t_trap(2'd3, 1, "R6 undef first");
    top_undef_prio = 0;
    t_trap(2'd1, 0, "R7 os over hyp");
    cur_lvl = 1;
    t_trap(2'd2, 0, "R8 hyp at lvl1");
    host_mode = 1;
    t_trap(2'd3, 0, "R9 host skips hyp");
    host_mode = 0; cur_lvl = 2;
    t_trap(2'd3, 0, "R8 lvl2 skips hyp");
    monitor_mode = 1;
    t_trap(2'd0, 0, "R9 monitor mode skips");
    monitor_mode = 0; top_present = 0;
    t_trap(2'd0, 0, "R9 absent level skips");
    top_present = 1; mon_trap_en = 0; cur_lvl = 0; os_trap_n = 1; hyp_trap_en = 0;
    t_trap(2'd0, 0, "R7 os_trap_n high no trap");
    finish_run();
  end
endmodule